// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block drives the column address sequence for one read or write burst inside a row that is already open in a two-bank synchronous DRAM. The memory controller presents a start column, a bank bit, the decoded burst-length code and the burst-ordering bit, and pulses `start`. From the next rising clock edge on, the block presents one column address per cycle with a valid strobe. On the final beat of a fixed-length burst it also raises a last-beat flag.

Fixed bursts of 1, 2, 4 or 8 beats wrap inside an aligned group of columns, in either counting order or exclusive-or order. The full-page mode walks the whole row and wraps from the top column to column zero. It runs until the controller asserts `stop`. The bursting configuration is captured at the start pulse, so the mode inputs may change while a burst is in flight. The column width is a parameter. The default of 9 bits gives 512 columns per row, and 8-bit and 10-bit columns also work.

Top module: `sdram_burst_colgen`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `beat_valid`, `beat_last`, `col_out` and `bank_out` are all zero.
- R2: A clock edge that samples `start` high presents beat 0 after that edge, with `col_out` equal to `start_col` and `bank_out` equal to `bank_sel`. This also holds when a burst is already running, which is abandoned.
- R3: `len_code` selects the burst length: 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8, and 7 gives full page. The codes 4, 5 and 6 give a single beat. A fixed burst keeps `beat_valid` high for exactly its length in cycles.
- R4: In a fixed burst of length L, every column bit at position log2(L) and above stays equal to the same bit of `start_col`.
- R5: With `ilv_order` = 0, beat n of a fixed burst has low bits equal to (start low bits + n) mod L.
- R6: With `ilv_order` = 1, beat n of a fixed burst has low bits equal to the start low bits XOR n.
- R7: In full-page mode the column rises by one per beat, wrapping from 2^COL_W-1 to 0, whatever `ilv_order` says.
- R8: `beat_last` is high on the final beat of a fixed burst only, and never during a full-page burst.
- R9: An edge that samples `stop` high while `start` is low ends any running burst, and `beat_valid` is low after that edge.
- R10: Changes to `start_col`, `bank_sel`, `len_code` and `ilv_order` while `start` is low have no effect on the burst in progress. Without `start`, an idle block stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a new burst on this edge |
| stop | input | 1 | Terminate the running burst |
| start_col | input | COL_W | First column of the burst |
| bank_sel | input | 1 | Bank bit for the burst |
| len_code | input | 3 | Burst length code (see R3) |
| ilv_order | input | 1 | 0 = counting order, 1 = XOR order |
| col_out | output | COL_W | Column address of the current beat |
| bank_out | output | 1 | Bank bit of the current burst |
| beat_valid | output | 1 | A beat is presented this cycle |
| beat_last | output | 1 | Current beat ends a fixed burst |

## Verification
The bound checker covers the behaviour that can be seen on every cycle:
- loading of the start column and bank on a start pulse;
- the valid strobe dropping after a last beat or a stop;
- the last-beat flag implying valid and staying quiet in full-page mode;
- an idle block remaining idle;
- the column advancing by one per beat in full-page mode.

The exact orderings need the bench's sweeps, which compare each beat against an arithmetic model:
- the counting and XOR sequences for every start column, every length and both banks;
- the upper-bit freezing;
- the burst lengths, including the reserved codes;
- the wrap from the top column;
- a restart in the middle of a burst;
- mode inputs changing during a burst.

// File: rtl/colgen_pkg.sv
package colgen_pkg;

  typedef enum logic [2:0] {
    LEN_1    = 3'd0,
    LEN_2    = 3'd1,
    LEN_4    = 3'd2,
    LEN_8    = 3'd3,
    LEN_PAGE = 3'd7
  } len_code_e;

  localparam int unsigned MAX_FIXED_LOG2 = 3;

endpackage

// File: rtl/colgen_mask.sv
// Turns a burst length code into a wrap mask (equal to length-1 for
// fixed bursts, all ones for full page) and a full-page flag.
module colgen_mask #(
  parameter int unsigned COL_W = 9
) (
  input  logic [2:0]       code,
  output logic [COL_W-1:0] wrap_mask,
  output logic             full_page
);
  import colgen_pkg::*;

  logic       fixed_ok;
  logic [1:0] fixed_log2;

  always_comb begin
    full_page  = (code == LEN_PAGE);
    fixed_ok   = (code <= LEN_8);
    fixed_log2 = code[1:0];
  end

  for (genvar i = 0; i < COL_W; i++) begin : g_bit
    if (i < MAX_FIXED_LOG2) begin : g_low
      assign wrap_mask[i] = full_page | (fixed_ok & (2'(i) < fixed_log2));
    end else begin : g_high
      assign wrap_mask[i] = full_page;
    end
  end

endmodule

// File: rtl/colgen_addr_mix.sv
// Combines the frozen start column with the beat count: counting order
// adds, XOR order flips. Bits outside the wrap mask keep the start value.
module colgen_addr_mix #(
  parameter int unsigned COL_W = 9
) (
  input  logic [COL_W-1:0] base_col,
  input  logic [COL_W-1:0] beat_cnt,
  input  logic [COL_W-1:0] wrap_mask,
  input  logic             xor_mode,
  output logic [COL_W-1:0] col
);
  logic [COL_W-1:0] sum_col;

  assign sum_col = base_col + beat_cnt;

  for (genvar i = 0; i < COL_W; i++) begin : g_bit
    assign col[i] = wrap_mask[i] ? (xor_mode ? (base_col[i] ^ beat_cnt[i]) : sum_col[i])
                                 : base_col[i];
  end

endmodule

// File: rtl/colgen_ctrl.sv
// Burst state: captured configuration and beat counter. Exposes the
// next-state values so the top can register its outputs from them.
module colgen_ctrl #(
  parameter int unsigned COL_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             stop,
  input  logic [COL_W-1:0] start_col,
  input  logic             bank_sel,
  input  logic [2:0]       len_code,
  input  logic             ilv_order,
  output logic             nx_active,
  output logic [COL_W-1:0] nx_cnt,
  output logic [COL_W-1:0] nx_base,
  output logic [COL_W-1:0] nx_mask,
  output logic             nx_bank,
  output logic             nx_xor,
  output logic             nx_last
);
  logic             act_q;
  logic [COL_W-1:0] cnt_q;
  logic [COL_W-1:0] base_q;
  logic [COL_W-1:0] mask_q;
  logic             bank_q;
  logic             xor_q;
  logic             full_q;
  logic             nx_full;

  logic [COL_W-1:0] in_mask;
  logic             in_full;
  logic             at_end;

  colgen_mask #(.COL_W(COL_W)) u_mask (
    .code      (len_code),
    .wrap_mask (in_mask),
    .full_page (in_full)
  );

  assign at_end = !full_q && (cnt_q == mask_q);

  always_comb begin
    nx_active = act_q;
    nx_cnt    = cnt_q;
    nx_base   = base_q;
    nx_mask   = mask_q;
    nx_bank   = bank_q;
    nx_xor    = xor_q;
    nx_full   = full_q;
    if (start) begin
      nx_active = 1'b1;
      nx_cnt    = '0;
      nx_base   = start_col;
      nx_mask   = in_mask;
      nx_bank   = bank_sel;
      nx_xor    = ilv_order & !in_full;
      nx_full   = in_full;
    end else if (act_q) begin
      if (stop || at_end) begin
        nx_active = 1'b0;
      end else begin
        nx_cnt = cnt_q + 1'b1;
      end
    end
    nx_last = nx_active && !nx_full && (nx_cnt == nx_mask);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= 1'b0;
      cnt_q  <= '0;
      base_q <= '0;
      mask_q <= '0;
      bank_q <= 1'b0;
      xor_q  <= 1'b0;
      full_q <= 1'b0;
    end else begin
      act_q  <= nx_active;
      cnt_q  <= nx_cnt;
      base_q <= nx_base;
      mask_q <= nx_mask;
      bank_q <= nx_bank;
      xor_q  <= nx_xor;
      full_q <= nx_full;
    end
  end

endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen #(
  parameter int unsigned COL_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             stop,
  input  logic [COL_W-1:0] start_col,
  input  logic             bank_sel,
  input  logic [2:0]       len_code,
  input  logic             ilv_order,
  output logic [COL_W-1:0] col_out,
  output logic             bank_out,
  output logic             beat_valid,
  output logic             beat_last
);
  logic             nx_active;
  logic [COL_W-1:0] nx_cnt;
  logic [COL_W-1:0] nx_base;
  logic [COL_W-1:0] nx_mask;
  logic             nx_bank;
  logic             nx_xor;
  logic             nx_last;
  logic [COL_W-1:0] nx_col;

  colgen_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .stop      (stop),
    .start_col (start_col),
    .bank_sel  (bank_sel),
    .len_code  (len_code),
    .ilv_order (ilv_order),
    .nx_active (nx_active),
    .nx_cnt    (nx_cnt),
    .nx_base   (nx_base),
    .nx_mask   (nx_mask),
    .nx_bank   (nx_bank),
    .nx_xor    (nx_xor),
    .nx_last   (nx_last)
  );

  colgen_addr_mix #(.COL_W(COL_W)) u_mix (
    .base_col  (nx_base),
    .beat_cnt  (nx_cnt),
    .wrap_mask (nx_mask),
    .xor_mode  (nx_xor),
    .col       (nx_col)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      col_out    <= '0;
      bank_out   <= 1'b0;
      beat_valid <= 1'b0;
      beat_last  <= 1'b0;
    end else begin
      col_out    <= nx_col;
      bank_out   <= nx_bank;
      beat_valid <= nx_active;
      beat_last  <= nx_last;
    end
  end

endmodule

// File: rtl/colgen_checker.sv
module colgen_checker #(
  parameter int unsigned COL_W = 9
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             stop,
  input logic [COL_W-1:0] start_col,
  input logic             bank_sel,
  input logic [2:0]       len_code,
  input logic [COL_W-1:0] col_out,
  input logic             bank_out,
  input logic             beat_valid,
  input logic             beat_last
);
  // Full-page mode seen by the checker, captured from the ports.
  logic page_mode;
  always_ff @(posedge clk) begin
    if (rst) page_mode <= 1'b0;
    else if (start) page_mode <= (len_code == 3'd7);
  end

  p_start_loads_r2: assert property (@(posedge clk) disable iff (rst)
    start |=> beat_valid && col_out == $past(start_col) && bank_out == $past(bank_sel));

  p_last_has_valid_r8: assert property (@(posedge clk) disable iff (rst)
    beat_last |-> beat_valid);

  p_page_no_last_r8: assert property (@(posedge clk) disable iff (rst)
    page_mode && beat_valid |-> !beat_last);

  p_last_ends_r3: assert property (@(posedge clk) disable iff (rst)
    beat_last && !start |=> !beat_valid);

  p_stop_ends_r9: assert property (@(posedge clk) disable iff (rst)
    stop && !start |=> !beat_valid);

  p_idle_stays_r10: assert property (@(posedge clk) disable iff (rst)
    !beat_valid && !start |=> !beat_valid);

  p_page_step_r7: assert property (@(posedge clk) disable iff (rst)
    page_mode && beat_valid && !start && !stop |=> col_out == $past(col_out) + 1'b1);

endmodule

bind sdram_burst_colgen colgen_checker #(.COL_W(COL_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .stop       (stop),
  .start_col  (start_col),
  .bank_sel   (bank_sel),
  .len_code   (len_code),
  .col_out    (col_out),
  .bank_out   (bank_out),
  .beat_valid (beat_valid),
  .beat_last  (beat_last)
);

// File: tb/sim_sdram_burst_colgen.sv
module sim_sdram_burst_colgen;
  localparam int unsigned COL_W = 9;
  localparam int unsigned NCOL  = 1 << COL_W;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start = 1'b0;
  logic             stop = 1'b0;
  logic [COL_W-1:0] start_col = '0;
  logic             bank_sel = 1'b0;
  logic [2:0]       len_code = 3'd0;
  logic             ilv_order = 1'b0;
  logic [COL_W-1:0] col_out;
  logic             bank_out;
  logic             beat_valid;
  logic             beat_last;

  int n_vec = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  sdram_burst_colgen #(.COL_W(COL_W)) u0 (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int blen(input int code);
    if (code == 7) return 0;
    if (code <= 3) return 1 << code;
    return 1;
  endfunction

  function automatic int exp_col(input int base, input int code, input int ilv, input int n);
    int l, off, hi;
    if (code == 7) return (base + n) % NCOL;
    l   = blen(code);
    off = base % l;
    hi  = base - off;
    if (ilv != 0) return hi + (off ^ n);
    return hi + ((off + n) % l);
  endfunction

  task automatic launch(input int col, input int code, input int ilv, input int bk);
    @(negedge clk);
    start     = 1'b1;
    start_col = COL_W'(col);
    len_code  = 3'(code);
    ilv_order = ilv[0];
    bank_sel  = bk[0];
  endtask

  // Checks a complete fixed burst; scramble disturbs mode inputs mid-burst.
  task automatic fixed_burst(input int col, input int code, input int ilv, input int bk,
                             input bit scramble);
    int l;
    l = blen(code);
    launch(col, code, ilv, bk);
    for (int n = 0; n < l; n++) begin
      @(negedge clk);
      start = 1'b0;
      if (scramble) begin
        start_col = ~start_col;
        len_code  = 3'd7;
        ilv_order = ~ilv_order;
        bank_sel  = ~bank_sel;
      end
      chk(scramble ? "R10 valid" : "R3 valid", beat_valid, 1);
      chk(ilv != 0 ? "R6 col" : "R5 col", col_out, exp_col(col, code, ilv, n));
      chk("R4 upper bits", col_out / l, col / l);
      chk("R2 bank", bank_out, bk);
      chk("R8 last", beat_last, (n == l - 1) ? 1 : 0);
    end
    @(negedge clk);
    chk("R3 length end", beat_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 valid", beat_valid, 0);
    chk("R1 last", beat_last, 0);
    chk("R1 col", col_out, 0);
    chk("R1 bank", bank_out, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after release", beat_valid, 0);

    // Sweep: every start column, all fixed lengths, both orders.
    for (int c = 0; c < int'(NCOL); c++)
      for (int code = 0; code < 4; code++)
        for (int ilv = 0; ilv < 2; ilv++)
          fixed_burst(c, code, ilv, (c + code) & 1, 1'b0);

    // Reserved codes give one beat.
    for (int code = 4; code < 7; code++) fixed_burst(37, code, 1, 1, 1'b0);

    // Mode inputs disturbed during a burst.
    fixed_burst(101, 3, 0, 1, 1'b1);
    fixed_burst(202, 2, 1, 0, 1'b1);

    // Full page from near the top, wraps, XOR order ignored, then stop.
    launch(NCOL - 3, 7, 1, 1);
    for (int n = 0; n < 8; n++) begin
      @(negedge clk);
      start = 1'b0;
      chk("R7 col", col_out, exp_col(NCOL - 3, 7, 0, n));
      chk("R8 page no last", beat_last, 0);
      chk("R7 valid", beat_valid, 1);
    end
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    chk("R9 page stop", beat_valid, 0);
    repeat (3) @(negedge clk);
    chk("R10 idle", beat_valid, 0);

    // Stop inside a fixed burst.
    launch(64, 3, 0, 0);
    for (int n = 0; n < 3; n++) begin
      @(negedge clk);
      start = 1'b0;
      chk("R5 col", col_out, 64 + n);
    end
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    chk("R9 fixed stop", beat_valid, 0);

    // Restart mid-burst.
    launch(16, 3, 0, 0);
    for (int n = 0; n < 3; n++) begin
      @(negedge clk);
      start = 1'b0;
    end
    launch(300, 2, 1, 1);
    @(negedge clk);
    start = 1'b0;
    chk("R2 restart col", col_out, 300);
    chk("R2 restart bank", bank_out, 1);
    for (int n = 1; n < 4; n++) begin
      @(negedge clk);
      chk("R6 restart seq", col_out, exp_col(300, 2, 1, n));
    end
    @(negedge clk);
    chk("R3 restart end", beat_valid, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule